// File: doc/BRIEF.md
# Quad-Port-Style Burst-of-Four SRAM Model

This block is a small, synthesizable stand-in for a synchronous SRAM whose read and write sides have their own data buses. Every access moves a group of four consecutive words. The caller gives a block address that has no two low bits. The model fills in those bits with a beat counter that starts at 0 and counts up to 3. A read command and a write command may be presented at the same rising edge, and both bursts then run side by side.

Double-data-rate transfer is modelled with one internal clock per beat, so a burst takes four cycles on each port. Each port has a small control machine with two states, `PS_IDLE` and `PS_BURST`, and four named transitions:
- `T_ACCEPT`: PS_IDLE to PS_BURST when the select is low.
- `T_STEP`: PS_BURST to PS_BURST while the beat counter is below 3.
- `T_CHAIN`: PS_BURST to PS_BURST, with the beat counter back at 0 and a new base address, when the select is low on the last beat.
- `T_DONE`: PS_BURST to PS_IDLE on the last beat when no new command is present.

Write beats carry their own active-low nibble masks and land in the array on the beat they arrive. A read beat that hits the word being written in the same cycle gets the merged new value. Read words pass through a register pipeline of `RD_LAT` stages before they reach the output, and a valid strobe marks them.

Top module: `qb4_sram`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it is released until a read is accepted, `rvalid` is 0 and `rdata` is 0. A reset during a burst ends it.
- R2: A write command (`wr_n` low at an edge while the write port is idle) is accepted. The four `wdata` beats sampled at the next four edges are stored at word addresses `{wr_addr,2'b00}`, `{wr_addr,2'b01}`, `{wr_addr,2'b10}` and `{wr_addr,2'b11}`, in that order.
- R3: If a read command is sampled at edge n, beat i (i = 0..3, word `{rd_addr,i}`) appears on `rdata` just after edge n+RD_LAT+i.
- R4: `rvalid` is 1 for exactly those four cycles of each read burst. It is 0 otherwise, and `rdata` is 0 whenever `rvalid` is 0.
- R5: `wmask_n` is sampled with each write beat. When `wmask_n[j]` is 0, bits 4j+3..4j of that beat are written. When it is 1, those bits keep their old value. A beat with all mask bits high changes nothing.
- R6: A read command and a write command sampled at the same edge are both accepted and run concurrently.
- R7: A read beat that samples the word being written by a write beat at the same edge returns the new word with that beat's masks applied.
- R8: A command on a port whose burst is on beat 0, 1 or 2 is ignored. It does not change that burst's addresses, does not add read beats and does not write memory.
- R9: A command sampled on a port's last beat (beat 3) starts a new burst with no gap. Two chained reads give eight consecutive valid cycles.
- R10: The port address width is log2(DEPTH)-2, and the highest block address reaches the top four words of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; one rising edge per transferred word |
| rst_n | input | 1 | Active-low synchronous reset of control and read pipeline |
| rd_n | input | 1 | Active-low read select |
| rd_addr | input | AW | Read block address (word address without two LSBs) |
| wr_n | input | 1 | Active-low write select |
| wr_addr | input | AW | Write block address (word address without two LSBs) |
| wdata | input | DW | Write data beat |
| wmask_n | input | DW/4 | Active-low nibble write enables, one per 4 data bits, sampled per beat |
| rdata | output | DW | Read data beat, zero when not valid |
| rvalid | output | 1 | Read data valid strobe |

## Verification
The write port storing a beat and the read port sampling the same word can fall in the same cycle. That is the case where the array alone would hand back stale data. The bench provokes it by issuing a read and a write to one block address at the same edge, with a different nibble mask on each beat, including fully masked and half-masked beats. It judges the read beats against a model held in the bench that applies the masked write before the read is evaluated. A chained pair of read and write bursts, and commands injected in the middle of a burst, check the same overlap across burst boundaries.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
    localparam int BEATS  = 4;
    localparam int BEAT_W = 2;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_BURST = 1'b1
    } port_state_e;
endpackage

// File: rtl/qb4_burst_ctrl.sv
module qb4_burst_ctrl
    import qb4_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_n,
    input  logic [AW-1:0]     cmd_addr,
    output logic              active,
    output logic [AW+BEAT_W-1:0] word_addr
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    port_state_e       state, state_nx;
    logic [BEAT_W-1:0] beat, beat_nx;
    logic [AW-1:0]     base, base_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            beat  <= '0;
            base  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
            base  <= base_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        beat_nx  = beat;
        base_nx  = base;
        unique case (state)
            PS_IDLE: begin
                if (!cmd_n) begin            // T_ACCEPT
                    state_nx = PS_BURST;
                    beat_nx  = '0;
                    base_nx  = cmd_addr;
                end
            end
            PS_BURST: begin
                if (beat != LAST_BEAT) begin // T_STEP, command ignored
                    beat_nx = beat + 1'b1;
                end else if (!cmd_n) begin   // T_CHAIN
                    beat_nx = '0;
                    base_nx = cmd_addr;
                end else begin               // T_DONE
                    state_nx = PS_IDLE;
                    beat_nx  = '0;
                end
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active    = (state == PS_BURST);
        word_addr = {base, beat};
    end

    // R2: beat counter advances by one inside a burst
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BURST && beat != LAST_BEAT)
        |=> (state == PS_BURST && beat == BEAT_W'($past(beat) + 1'b1)));

    // R2: an accepted command starts at beat 0 on its own address
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE && !cmd_n)
        |=> (state == PS_BURST && beat == '0 && base == $past(cmd_addr)));

    // R8: mid-burst commands leave the block address untouched
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BURST && beat != LAST_BEAT) |=> $stable(base));

    // R9: a command on the last beat chains without a gap
    p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BURST && beat == LAST_BEAT && !cmd_n)
        |=> (state == PS_BURST && beat == '0 && base == $past(cmd_addr)));
endmodule

// File: rtl/qb4_storage.sv
module qb4_storage #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [DW/4-1:0]          wmask_n,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rword
);
    localparam int NIB = DW / 4;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] bitsel;
    logic [DW-1:0] merged;
    logic          fwd_hit;

    for (genvar g = 0; g < NIB; g++) begin : g_nib
        assign bitsel[4*g +: 4] = {4{~wmask_n[g]}};
    end

    assign merged  = (mem[waddr] & ~bitsel) | (wdata & bitsel);
    assign fwd_hit = wr_en && (raddr == waddr);
    assign rword   = fwd_hit ? merged : mem[raddr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr] <= merged;
        end
    end

    // R5: a fully masked beat leaves the word unchanged
    p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wmask_n)) |=> (mem[$past(waddr)] == $past(mem[waddr])));

    // R7: the forwarded word is exactly what the array then holds
    p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |=> (mem[$past(waddr)] == $past(rword)));
endmodule

// File: rtl/qb4_read_pipe.sv
module qb4_read_pipe #(
    parameter int DW  = 8,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic          v [LAT];
    logic [DW-1:0] d [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v[0] <= 1'b0;
                    d[0] <= '0;
                end else begin
                    v[0] <= in_valid;
                    d[0] <= in_valid ? in_data : '0;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v[s] <= 1'b0;
                    d[s] <= '0;
                end else begin
                    v[s] <= v[s-1];
                    d[s] <= d[s-1];
                end
            end
        end
    end

    assign out_valid = v[LAT-1];
    assign out_data  = d[LAT-1];
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
    import qb4_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 64,
    parameter int RD_LAT = 2,
    localparam int AW    = $clog2(DEPTH) - BEAT_W,
    localparam int NIB   = DW / 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_n,
    input  logic [AW-1:0]  rd_addr,
    input  logic           wr_n,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NIB-1:0] wmask_n,
    output logic [DW-1:0]  rdata,
    output logic           rvalid
);
    localparam int WA = AW + BEAT_W;

    logic          w_active, r_active;
    logic [WA-1:0] w_word, r_word;
    logic [DW-1:0] rd_word;

    qb4_burst_ctrl #(.AW(AW)) u_wctl (
        .clk(clk), .rst_n(rst_n), .cmd_n(wr_n), .cmd_addr(wr_addr),
        .active(w_active), .word_addr(w_word)
    );

    qb4_burst_ctrl #(.AW(AW)) u_rctl (
        .clk(clk), .rst_n(rst_n), .cmd_n(rd_n), .cmd_addr(rd_addr),
        .active(r_active), .word_addr(r_word)
    );

    qb4_storage #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(w_active), .waddr(w_word),
        .wdata(wdata), .wmask_n(wmask_n), .raddr(r_word), .rword(rd_word)
    );

    qb4_read_pipe #(.DW(DW), .LAT(RD_LAT)) u_rpipe (
        .clk(clk), .rst_n(rst_n), .in_valid(r_active), .in_data(rd_word),
        .out_valid(rvalid), .out_data(rdata)
    );

    // R1: reset leaves the read side quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rvalid && rdata == '0));
endmodule

// File: tb/qb4_sram_test.sv
module qb4_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW     = 8;
    localparam int DEPTH  = 64;
    localparam int RD_LAT = 2;
    localparam int AW     = 4;
    localparam int NIB    = 2;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] ra;
        logic          wr;
        logic [AW-1:0] wa;
        logic [31:0]   dat;
        logic [7:0]    msk;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd0,  1'b1, 4'd3,  32'h44332211, 8'h00},
        '{1'b1, 4'd3,  1'b0, 4'd0,  32'h00000000, 8'hFF},
        '{1'b0, 4'd0,  1'b1, 4'd3,  32'hAABBCCDD, 8'b01_10_11_00},
        '{1'b1, 4'd3,  1'b0, 4'd0,  32'h00000000, 8'hFF},
        '{1'b1, 4'd5,  1'b1, 4'd5,  32'h13579BDF, 8'b00_01_10_00},
        '{1'b1, 4'd7,  1'b1, 4'd2,  32'hF0E1D2C3, 8'h00},
        '{1'b1, 4'd2,  1'b0, 4'd0,  32'h00000000, 8'hFF},
        '{1'b0, 4'd0,  1'b1, 4'd15, 32'hDEADBEEF, 8'h00},
        '{1'b1, 4'd15, 1'b1, 4'd0,  32'h01020304, 8'hFF},
        '{1'b1, 4'd0,  1'b0, 4'd0,  32'h00000000, 8'hFF}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           rd_n, wr_n;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic [DW-1:0]  wdata;
    logic [NIB-1:0] wmask_n;
    logic [DW-1:0]  rdata;
    logic           rvalid;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    logic [7:0] model [DEPTH];

    qb4_sram #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .wdata(wdata), .wmask_n(wmask_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_write(input logic [AW-1:0] wa, input logic [31:0] dat, input logic [7:0] msk);
        for (int i = 0; i < 4; i++) begin
            for (int n = 0; n < NIB; n++) begin
                if (!msk[2*i+n]) model[wa*4+i][4*n +: 4] = dat[8*i+4*n +: 4];
            end
        end
    endtask

    // one command slot with optional injected mid-burst commands
    task automatic run_burst(input logic do_rd, input logic [AW-1:0] ra,
                             input logic do_wr, input logic [AW-1:0] wa,
                             input logic [31:0] dat, input logic [7:0] msk,
                             input int inj, input logic [AW-1:0] ia,
                             input string tag);
        logic [7:0] expv [4];
        logic       vexp;
        if (do_wr) model_write(wa, dat, msk);
        for (int i = 0; i < 4; i++) expv[i] = model[ra*4+i];
        rd_n = !do_rd; rd_addr = ra; wr_n = !do_wr; wr_addr = wa;
        tick();
        rd_n = 1'b1; wr_n = 1'b1;
        for (int c = 0; c <= RD_LAT + 4; c++) begin
            vexp = do_rd && (c >= RD_LAT) && (c < RD_LAT + 4);
            chk({tag, " R4 valid"}, 32'(rvalid), 32'(vexp));
            if (vexp) chk({tag, " R3 data"}, 32'(rdata), 32'(expv[c-RD_LAT]));
            else      chk({tag, " R4 idle data"}, 32'(rdata), 32'h0);
            if (c < 4) begin
                wdata = dat[8*c +: 8]; wmask_n = msk[2*c +: 2];
            end else begin
                wdata = '0; wmask_n = '1;
            end
            if (c == inj) begin
                rd_n = 1'b0; wr_n = 1'b0; rd_addr = ia; wr_addr = ia;
            end else begin
                rd_n = 1'b1; wr_n = 1'b1;
            end
            tick();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R1 actual hung expected done");
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t  v;
        string tag;
        rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        rd_addr = '0; wr_addr = '0; wdata = '0; wmask_n = '1;
        repeat (3) tick();
        chk("R1 reset valid", 32'(rvalid), 32'h0);
        chk("R1 reset data", 32'(rdata), 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R1 after reset valid", 32'(rvalid), 32'h0);
            chk("R1 after reset data", 32'(rdata), 32'h0);
        end

        // fill the whole array, highest block included (R10)
        for (int b = 0; b < DEPTH/4; b++) begin
            logic [31:0] fill;
            for (int i = 0; i < 4; i++) fill[8*i +: 8] = 8'((b*16 + i) ^ 8'h5A);
            run_burst(1'b0, '0, 1'b1, AW'(b), fill, 8'h00, -1, '0, "R2 fill");
        end

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            if (v.rd && v.wr && v.ra == v.wa)          tag = "R7 R6";
            else if (v.rd && v.wr)                     tag = "R6";
            else if (v.ra == 4'd15 || v.wa == 4'd15)   tag = "R10";
            else if (v.wr && v.msk != 8'h00)           tag = "R5";
            else                                       tag = "R2/R3";
            if (v.rd && v.wr && v.msk == 8'hFF)        tag = "R5 R6";
            run_burst(v.rd, v.ra, v.wr, v.wa, v.dat, v.msk, -1, '0, tag);
        end
        run_burst(1'b1, 4'd15, 1'b0, '0, 32'h0, 8'hFF, -1, '0, "R10 top block");

        // mid-burst commands are ignored
        run_burst(1'b1, 4'd4, 1'b1, 4'd6, 32'h77665544, 8'h00, 1, 4'd12, "R8 inj1");
        run_burst(1'b1, 4'd6, 1'b1, 4'd9, 32'h0BADF00D, 8'h00, 2, 4'd12, "R8 inj2");
        run_burst(1'b1, 4'd12, 1'b0, '0, 32'h0, 8'hFF, -1, '0, "R8 untouched");
        run_burst(1'b1, 4'd9, 1'b0, '0, 32'h0, 8'hFF, -1, '0, "R8 written");

        // chained reads of blocks 8,9 and chained writes of blocks 10,11 (R9)
        model_write(4'd10, 32'h53525150, 8'h00);
        model_write(4'd11, 32'h57565554, 8'h00);
        rd_n = 1'b0; rd_addr = 4'd8; wr_n = 1'b0; wr_addr = 4'd10;
        tick();
        for (int c = 0; c <= RD_LAT + 8; c++) begin
            logic vx;
            vx = (c >= RD_LAT) && (c < RD_LAT + 8);
            chk("R9 chain valid", 32'(rvalid), 32'(vx));
            if (vx) chk("R9 chain data", 32'(rdata), 32'(model[32 + c - RD_LAT]));
            wdata = (c < 8) ? 8'(8'h50 + c) : 8'h00;
            wmask_n = (c < 8) ? 2'b00 : 2'b11;
            if (c == 3) begin
                rd_n = 1'b0; rd_addr = 4'd9; wr_n = 1'b0; wr_addr = 4'd11;
            end else begin
                rd_n = 1'b1; wr_n = 1'b1;
            end
            tick();
        end
        run_burst(1'b1, 4'd10, 1'b0, '0, 32'h0, 8'hFF, -1, '0, "R9 chained write a");
        run_burst(1'b1, 4'd11, 1'b0, '0, 32'h0, 8'hFF, -1, '0, "R9 chained write b");

        // reset in the middle of a read burst
        rd_n = 1'b0; rd_addr = 4'd3;
        tick();
        rd_n = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        chk("R1 mid-burst reset valid", 32'(rvalid), 32'h0);
        chk("R1 mid-burst reset data", 32'(rdata), 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk("R1 burst ended valid", 32'(rvalid), 32'h0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule